// File: doc/BRIEF.md
# Unidirectional Block Disparity Search

This block finds the disparity vector of one 8x8 pixel block taken from a predicted elemental image. It slides an 8x8 window along a single horizontal direction across a reference strip. The strip holds the eight matching rows of the reference elemental image and is BLK+NUM_OFF-1 columns wide. Every offset in the fixed window is evaluated: the block accumulates the sum of absolute differences (SAD) for each candidate, and a sequential comparator keeps the smallest value seen so far.

After the search the block reads the current block a second time, together with the reference block at the winning offset. It streams out the signed pixel residual, which an encoder back end would go on to transform and code. Pixel storage sits outside the block. The block drives one read address for the current block and one for the reference strip. Both buffers answer with registered reads, so data returns one cycle after its address is presented. One pixel pair is consumed per cycle.

A search is launched with a start pulse. It ends with a one-cycle done pulse, after which the vector and the minimum SAD stay on the outputs until the next start.

Top module: `disp_search`

## Requirements
- R1: `min_sad` reports the smallest SAD among all candidates. A candidate's SAD is the sum of |cur - ref| over all 64 pixel pairs of the 8x8 blocks.
- R2: The offsets 0 to NUM_OFF-1 (16 by default) are all evaluated. `vec` reports the offset whose SAD is minimal.
- R3: When several offsets share the minimal SAD, `vec` reports the smallest of them.
- R4: Pixel index p = row*8 + col, in raster order. `cur_addr` = p. `ref_addr` = row*(8+NUM_OFF-1) + col + offset, which is row*23 + col + offset by default, and stays below 8*23. Read data is taken one clock cycle after its address.
- R5: After the search, exactly 64 residuals are driven on `res_data`, each with `res_valid` high. They come in raster order. Each is the 9-bit two's complement value cur - ref at the winning offset. `res_valid` is only high while `busy` is high.
- R6: `start` is sampled while the block is idle. Let cycle 0 be that cycle. `busy` is high from cycle 1 until `done` rises. `done` is a single-cycle pulse in cycle NUM_OFF*64+64+6, which is cycle 1094 by default, and `busy` is low in that cycle.
- R7: A `start` pulse while `busy` is high has no effect on the results, the residual stream or the timing of `done`.
- R8: While the block is idle and `start` is low, `vec` and `min_sad` stay unchanged.
- R9: While reset is asserted and after it is released, `busy`, `done` and `res_valid` are low and `vec` and `min_sad` are zero.
- R10: The extreme cases are carried exactly. A SAD of 64*255 = 16320 fits `min_sad`. Residuals of +255 and -255 are reported without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a search (accepted when idle) |
| busy | output | 1 | Search or residual phase in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_addr | output | 6 | Read address into the current-block buffer |
| cur_data | input | 8 | Current-block pixel, one cycle after its address |
| ref_addr | output | 8 | Read address into the reference strip buffer |
| ref_data | input | 8 | Reference pixel, one cycle after its address |
| vec | output | 4 | Winning disparity offset |
| min_sad | output | 14 | SAD of the winning offset |
| res_valid | output | 1 | Residual strobe |
| res_data | output | 9 | Signed residual cur - ref |

## Verification
The bound assertions watch the handshake on every cycle: `done` is a lone pulse with `busy` low, `busy` rises only after a `start`, residuals appear only while busy, results hold while idle, the reference address stays inside the strip and the SAD stays within its 16320 bound. The values themselves can only be shown by the bench's scenarios. Those scenarios cover the winning offset and its SAD, the tie rule, the exact residual stream, the done latency and immunity to a stray start, on random blocks near a planted match and on directed tie and saturation patterns.

// File: rtl/disp_search_pkg.sv
package disp_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RESID  = 2'd2
  } ds_state_e;

endpackage

// File: rtl/ds_addr_gen.sv
module ds_addr_gen #(
  parameter int BLK     = 8,
  parameter int NUM_OFF = 16,
  localparam int IDX_W  = (BLK > 1) ? $clog2(BLK) : 1,
  localparam int OFF_W  = (NUM_OFF > 1) ? $clog2(NUM_OFF) : 1,
  localparam int REF_W  = BLK + NUM_OFF - 1,
  localparam int PIX_AW = $clog2(BLK * BLK),
  localparam int REF_AW = $clog2(BLK * REF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_search,
  input  logic              go_resid,
  input  logic [OFF_W-1:0]  best_off,
  output logic [PIX_AW-1:0] cur_addr,
  output logic [REF_AW-1:0] ref_addr,
  output logic              iss_vld,
  output logic              iss_resid,
  output logic              iss_last_pix,
  output logic              iss_last_all
);

  logic [IDX_W-1:0] row_q, col_q;
  logic [OFF_W-1:0] off_q;
  logic             active_q, resid_q;

  assign iss_last_pix = (row_q == IDX_W'(BLK - 1)) && (col_q == IDX_W'(BLK - 1));
  assign iss_last_all = iss_last_pix && (resid_q || (off_q == OFF_W'(NUM_OFF - 1)));
  assign iss_vld      = active_q;
  assign iss_resid    = resid_q;

  assign cur_addr = PIX_AW'(row_q) * PIX_AW'(BLK) + PIX_AW'(col_q);
  assign ref_addr = REF_AW'(row_q) * REF_AW'(REF_W) + REF_AW'(col_q) + REF_AW'(off_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      col_q    <= '0;
      off_q    <= '0;
      active_q <= 1'b0;
      resid_q  <= 1'b0;
    end else if (go_search) begin
      row_q    <= '0;
      col_q    <= '0;
      off_q    <= '0;
      active_q <= 1'b1;
      resid_q  <= 1'b0;
    end else if (go_resid) begin
      row_q    <= '0;
      col_q    <= '0;
      off_q    <= best_off;
      active_q <= 1'b1;
      resid_q  <= 1'b1;
    end else if (active_q) begin
      if (col_q == IDX_W'(BLK - 1)) begin
        col_q <= '0;
        if (row_q == IDX_W'(BLK - 1)) begin
          row_q <= '0;
          if (iss_last_all) active_q <= 1'b0;
          else              off_q    <= off_q + 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ds_sad_acc.sv
module ds_sad_acc #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 64,
  localparam int SAD_W = $clog2(NPIX * ((1 << PIX_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_last_pix,
  input  logic             in_last_all,
  input  logic [PIX_W-1:0] cur_px,
  input  logic [PIX_W-1:0] ref_px,
  output logic             cand_vld,
  output logic             cand_last,
  output logic [SAD_W-1:0] cand_sad
);

  logic [SAD_W-1:0] acc_q;
  logic [PIX_W-1:0] absd;

  always_comb begin
    if (cur_px >= ref_px) absd = cur_px - ref_px;
    else                  absd = ref_px - cur_px;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cand_vld  <= 1'b0;
      cand_last <= 1'b0;
      cand_sad  <= '0;
    end else begin
      cand_vld  <= 1'b0;
      cand_last <= 1'b0;
      if (in_vld) begin
        if (in_last_pix) begin
          acc_q     <= '0;
          cand_sad  <= acc_q + SAD_W'(absd);
          cand_vld  <= 1'b1;
          cand_last <= in_last_all;
        end else begin
          acc_q <= acc_q + SAD_W'(absd);
        end
      end
    end
  end

endmodule

// File: rtl/ds_min_cmp.sv
module ds_min_cmp #(
  parameter int SAD_W = 14,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cand_vld,
  input  logic             cand_last,
  input  logic [SAD_W-1:0] cand_sad,
  output logic [SAD_W-1:0] best_sad,
  output logic [OFF_W-1:0] best_off,
  output logic             fin
);

  logic             seen_q;
  logic [OFF_W-1:0] cand_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      cand_off_q <= '0;
      best_sad   <= '0;
      best_off   <= '0;
      fin        <= 1'b0;
    end else begin
      fin <= cand_vld && cand_last;
      if (clear) begin
        seen_q     <= 1'b0;
        cand_off_q <= '0;
      end else if (cand_vld) begin
        cand_off_q <= cand_off_q + 1'b1;
        seen_q     <= 1'b1;
        if (!seen_q || (cand_sad < best_sad)) begin
          best_sad <= cand_sad;
          best_off <= cand_off_q;
        end
      end
    end
  end

endmodule

// File: rtl/disp_search.sv
module disp_search
  import disp_search_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int BLK     = 8,
  parameter int NUM_OFF = 16,
  localparam int NPIX   = BLK * BLK,
  localparam int OFF_W  = (NUM_OFF > 1) ? $clog2(NUM_OFF) : 1,
  localparam int SAD_W  = $clog2(NPIX * ((1 << PIX_W) - 1) + 1),
  localparam int REF_W  = BLK + NUM_OFF - 1,
  localparam int PIX_AW = $clog2(NPIX),
  localparam int REF_AW = $clog2(BLK * REF_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [PIX_AW-1:0]       cur_addr,
  input  logic [PIX_W-1:0]        cur_data,
  output logic [REF_AW-1:0]       ref_addr,
  input  logic [PIX_W-1:0]        ref_data,
  output logic [OFF_W-1:0]        vec,
  output logic [SAD_W-1:0]        min_sad,
  output logic                    res_valid,
  output logic signed [PIX_W:0]   res_data
);

  ds_state_e state_q;

  logic go_search, go_resid;
  logic iss_vld, iss_resid, iss_last_pix, iss_last_all;
  logic s1_vld, s1_resid, s1_last_pix, s1_last_all;
  logic cand_vld, cand_last, cmp_fin;
  logic [SAD_W-1:0] cand_sad;
  logic res_last;

  assign go_search = (state_q == ST_IDLE) && start;
  assign go_resid  = (state_q == ST_SEARCH) && cmp_fin;
  assign busy      = (state_q != ST_IDLE);

  ds_addr_gen #(.BLK(BLK), .NUM_OFF(NUM_OFF)) i_addr (
    .clk          (clk),
    .rst          (rst),
    .go_search    (go_search),
    .go_resid     (go_resid),
    .best_off     (vec),
    .cur_addr     (cur_addr),
    .ref_addr     (ref_addr),
    .iss_vld      (iss_vld),
    .iss_resid    (iss_resid),
    .iss_last_pix (iss_last_pix),
    .iss_last_all (iss_last_all)
  );

  // tags travel alongside the one-cycle buffer read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld      <= 1'b0;
      s1_resid    <= 1'b0;
      s1_last_pix <= 1'b0;
      s1_last_all <= 1'b0;
    end else begin
      s1_vld      <= iss_vld;
      s1_resid    <= iss_resid;
      s1_last_pix <= iss_last_pix;
      s1_last_all <= iss_last_all;
    end
  end

  ds_sad_acc #(.PIX_W(PIX_W), .NPIX(NPIX)) i_sad (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (s1_vld && !s1_resid),
    .in_last_pix (s1_last_pix),
    .in_last_all (s1_last_all),
    .cur_px      (cur_data),
    .ref_px      (ref_data),
    .cand_vld    (cand_vld),
    .cand_last   (cand_last),
    .cand_sad    (cand_sad)
  );

  ds_min_cmp #(.SAD_W(SAD_W), .OFF_W(OFF_W)) i_cmp (
    .clk       (clk),
    .rst       (rst),
    .clear     (go_search),
    .cand_vld  (cand_vld),
    .cand_last (cand_last),
    .cand_sad  (cand_sad),
    .best_sad  (min_sad),
    .best_off  (vec),
    .fin       (cmp_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_last  <= 1'b0;
    end else begin
      res_valid <= s1_vld && s1_resid;
      res_last  <= s1_vld && s1_resid && s1_last_all;
      if (s1_vld && s1_resid)
        res_data <= $signed({1'b0, cur_data}) - $signed({1'b0, ref_data});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE:   if (start) state_q <= ST_SEARCH;
        ST_SEARCH: if (cmp_fin) state_q <= ST_RESID;
        ST_RESID: begin
          if (res_last) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/disp_search_chk.sv
module disp_search_chk #(
  parameter int PIX_W   = 8,
  parameter int BLK     = 8,
  parameter int NUM_OFF = 16,
  localparam int NPIX   = BLK * BLK,
  localparam int OFF_W  = (NUM_OFF > 1) ? $clog2(NUM_OFF) : 1,
  localparam int SAD_W  = $clog2(NPIX * ((1 << PIX_W) - 1) + 1),
  localparam int REF_W  = BLK + NUM_OFF - 1,
  localparam int REF_AW = $clog2(BLK * REF_W),
  localparam int SAD_MAX = NPIX * ((1 << PIX_W) - 1),
  localparam int REF_DEPTH = BLK * REF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [REF_AW-1:0] ref_addr,
  input logic [OFF_W-1:0]  vec,
  input logic [SAD_W-1:0]  min_sad,
  input logic              res_valid
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy);  // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));  // R6
  AST_RES_IN_BUSY: assert property (@(posedge clk) disable iff (rst) res_valid |-> busy);  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> ($stable(vec) && $stable(min_sad)));  // R8
  AST_SAD_BOUND: assert property (@(posedge clk) disable iff (rst) int'(min_sad) <= SAD_MAX);  // R10
  AST_REF_IN_STRIP: assert property (@(posedge clk) disable iff (rst) int'(ref_addr) < REF_DEPTH);  // R4

endmodule

bind disp_search disp_search_chk #(.PIX_W(PIX_W), .BLK(BLK), .NUM_OFF(NUM_OFF)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ref_addr  (ref_addr),
  .vec       (vec),
  .min_sad   (min_sad),
  .res_valid (res_valid)
);

// File: tb/test_disp_search.sv
module test_disp_search;

  localparam int NOFF  = 16;
  localparam int REFW  = 8 + NOFF - 1;
  localparam int LAT   = NOFF * 64 + 64 + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, res_valid;
  logic [5:0] cur_addr;
  logic [7:0] ref_addr;
  logic [7:0] cur_data, ref_data;
  logic [3:0] vec;
  logic [13:0] min_sad;
  logic signed [8:0] res_data;

  logic [7:0] cur_mem [64];
  logic [7:0] ref_mem [8*REFW];

  int total = 0;
  int bad = 0;
  int seed_tmp;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cur_data <= cur_mem[cur_addr];
    ref_data <= ref_mem[ref_addr];
  end

  disp_search i_disp_search (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cur_addr(cur_addr), .cur_data(cur_data),
    .ref_addr(ref_addr), .ref_data(ref_data),
    .vec(vec), .min_sad(min_sad),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sad_at(input int off);
    int s = 0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        int a = cur_mem[r*8+c];
        int b = ref_mem[r*REFW + c + off];
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  function automatic int best_off_model();
    int bo = 0;
    int bs = sad_at(0);
    for (int o = 1; o < NOFF; o++)
      if (sad_at(o) < bs) begin bs = sad_at(o); bo = o; end
    return bo;
  endfunction

  function automatic int resid_model(input int off, input int p);
    return int'(cur_mem[p]) - int'(ref_mem[(p/8)*REFW + (p%8) + off]);
  endfunction

  task automatic run_search(input string name, input bit stray_start,
                            input int exp_vec_force);
    int n = 0;
    int res_n = 0;
    int res_bad = 0;
    int first_bad_act = 0;
    int first_bad_exp = 0;
    int busy_at1 = 0;
    int eo, es;
    int got_lat = -1;
    eo = best_off_model();
    es = sad_at(eo);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 1;
    busy_at1 = busy;
    forever begin
      if (res_valid) begin
        if (res_n < 64 && int'(res_data) != resid_model(eo, res_n)) begin
          if (res_bad == 0) begin
            first_bad_act = int'(res_data);
            first_bad_exp = resid_model(eo, res_n);
          end
          res_bad++;
        end
        res_n++;
      end
      if (done) begin got_lat = n; break; end
      if (n > LAT + 200) break;
      @(negedge clk);
      n++;
      if (stray_start && n == 500) start = 1'b1;
      if (stray_start && n == 501) start = 1'b0;
    end
    $display("scenario %s: vec=%0d sad=%0d", name, vec, min_sad);
    chk(busy_at1 == 1, "R6", {name, " busy after start"}, busy_at1, 1);
    chk(got_lat == LAT, "R6", {name, " done latency"}, got_lat, LAT);
    chk(busy == 0, "R6", {name, " busy low at done"}, busy, 0);
    chk(int'(vec) == eo, "R2", {name, " vector"}, vec, eo);
    chk(int'(min_sad) == es, "R1", {name, " min sad"}, min_sad, es);
    if (exp_vec_force >= 0)
      chk(int'(vec) == exp_vec_force, "R3", {name, " directed vector"}, vec, exp_vec_force);
    chk(res_n == 64, "R5", {name, " residual count"}, res_n, 64);
    chk(res_bad == 0, "R5", {name, " residual values"}, first_bad_act, first_bad_exp);
    if (stray_start)
      chk(got_lat == LAT && int'(vec) == eo, "R7", {name, " stray start ignored"}, got_lat, LAT);
  endtask

  task automatic fill_random_planted(input int off, input int noise);
    for (int i = 0; i < 8*REFW; i++) ref_mem[i] = 8'($urandom_range(0, 255));
    for (int p = 0; p < 64; p++) begin
      int v = int'(ref_mem[(p/8)*REFW + (p%8) + off]) + int'($urandom_range(0, noise)) - noise/2;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      cur_mem[p] = 8'(v);
    end
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_tmp = $urandom(32'h5EED);
    for (int i = 0; i < 64; i++) cur_mem[i] = 8'd0;
    for (int i = 0; i < 8*REFW; i++) ref_mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 0 && done == 0 && res_valid == 0, "R9", "control in reset",
        {busy, done, res_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(vec == 0 && min_sad == 0, "R9", "results after reset", min_sad, 0);
    chk(busy == 0, "R9", "busy after reset", busy, 0);

    // R3: flat images, every offset ties at zero
    for (int i = 0; i < 64; i++) cur_mem[i] = 8'd100;
    for (int i = 0; i < 8*REFW; i++) ref_mem[i] = 8'd100;
    run_search("flat_tie", 1'b0, 0);

    // R3: column-periodic strip, offsets 1,5,9,13 match exactly
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < REFW; c++) ref_mem[r*REFW + c] = 8'(20 + 50*(c % 4) + r);
    for (int p = 0; p < 64; p++) cur_mem[p] = ref_mem[(p/8)*REFW + (p%8) + 1];
    run_search("periodic_tie", 1'b0, 1);

    // R10: saturated positive residual and maximal SAD
    for (int i = 0; i < 64; i++) cur_mem[i] = 8'd255;
    for (int i = 0; i < 8*REFW; i++) ref_mem[i] = 8'd0;
    run_search("max_pos", 1'b0, 0);
    chk(min_sad == 14'd16320, "R10", "max sad", min_sad, 16320);

    // R10: saturated negative residual
    for (int i = 0; i < 64; i++) cur_mem[i] = 8'd0;
    for (int i = 0; i < 8*REFW; i++) ref_mem[i] = 8'd255;
    run_search("max_neg", 1'b0, 0);

    // R2 R4: match planted at the last offset
    fill_random_planted(NOFF - 1, 0);
    run_search("last_offset", 1'b0, NOFF - 1);

    // R7: stray start while busy
    fill_random_planted(6, 8);
    run_search("stray_start", 1'b1, -1);

    // R8: results hold while idle, even when the buffers change
    begin
      logic [3:0] v0;
      logic [13:0] s0;
      v0 = vec;
      s0 = min_sad;
      for (int i = 0; i < 64; i++) cur_mem[i] = 8'($urandom_range(0, 255));
      repeat (20) @(negedge clk);
      chk(vec == v0 && min_sad == s0, "R8", "hold while idle", min_sad, s0);
    end

    // R1 R2 R5: random blocks near a planted match
    for (int k = 0; k < 6; k++) begin
      fill_random_planted(int'($urandom_range(0, NOFF - 1)), 16 * k);
      run_search($sformatf("random%0d", k), 1'b0, -1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule